// File: doc/BRIEF.md
# Procedure Return Address Stack

This block predicts where a procedure return will land. It watches a stream of pre-decoded instruction descriptors, one per cycle. Each descriptor carries a class code, a destination register number, a source or base register number and the instruction address. A call-type operation pushes a return address onto a small circular stack. A return-type write to the program counter pops the stack, and the popped address appears as a one-cycle prediction strobe. Calls and returns are recognised by the registers involved as well as by dedicated call opcodes. Copying the program counter into the link register counts as a call prelude, and the link value it produces is the address pushed.

The descriptor input has no back-pressure. The block accepts one descriptor in every cycle in which `op_valid` is high and never stalls, so it has no ready signal. A descriptor with `op_valid` low is not an operation. The prediction output has no ready either. `pred_valid` is a strobe that is high for exactly one cycle, and `pred_target` is meaningful only in that cycle. The stack works only while both the global flow-prediction enable and the stack's own enable are high. Both enables are plain level inputs. The controlling logic holds them at 0 out of reset.

Top module: `ras_predictor`

## Requirements
- R1: While `rst_n` is low and after it returns high, `pred_valid` is 0 and the stack is empty, so the first return after any reset produces no prediction.
- R2: A valid descriptor with class 1 (immediate branch-with-link) or class 2 (immediate branch-link-exchange) pushes `op_addr + 4`.
- R3: A valid descriptor with class 4 (move/ALU), destination 14 and source 15 pushes `op_addr + 8`, the program-counter read value that lands in the link register.
- R4: A valid descriptor with class 3 (load), destination 15 and base 13 pops the stack. In the next cycle `pred_valid` is 1 for one cycle and `pred_target` is the popped address.
- R5: A valid descriptor with class 4, destination 15 and source 14 pops the stack with the same output timing as R4.
- R6: Pops return addresses in last-in first-out order.
- R7: The stack holds DEPTH entries (default 4). A push when the stack is full overwrites the oldest entry, so after DEPTH+1 pushes the pops return the newest DEPTH addresses.
- R8: A pop when the stack is empty gives `pred_valid` 0 in the next cycle.
- R9: While `flow_en` or `stack_en` is 0, no descriptor pushes, pops or raises `pred_valid`, and the stack contents are kept.
- R10: A descriptor with `op_valid` low has no effect.
- R11: Descriptors of class 0 (other), loads to register 15 with a base other than 13, and other register combinations neither push nor pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| flow_en | input | 1 | Global program-flow prediction enable |
| stack_en | input | 1 | Return stack enable |
| op_valid | input | 1 | Descriptor present this cycle |
| op_class | input | 3 | 0 other, 1 branch-with-link, 2 branch-link-exchange, 3 load, 4 move/ALU |
| op_dst | input | 4 | Destination register number |
| op_src | input | 4 | Source operand or load base register number |
| op_addr | input | AW (32) | Instruction address |
| pred_valid | output | 1 | One-cycle strobe: predicted return target is valid |
| pred_target | output | AW (32) | Predicted return address |

## Verification
A wrong pushed value or a wrong read index shows up as a wrong `pred_target` in the cycle after the return that consumes that entry. That return may come many descriptors after the fault. A corrupted write pointer is also hidden until a pop, and it then breaks the last-in first-out order of R6 or the overwrite order of R7. An occupancy count that is off shows up at the first pop on a supposedly empty stack, as a stray strobe or as a prediction that is missing when it was due. A gate that leaks while the block is disabled is exposed only when the block is re-enabled and a pop returns the wrong entry.

// File: rtl/ras_pkg.sv
package ras_pkg;
  typedef enum logic [2:0] {
    OPC_OTHER   = 3'd0,
    OPC_BL_IMM  = 3'd1,
    OPC_BLX_IMM = 3'd2,
    OPC_LOAD    = 3'd3,
    OPC_MOVALU  = 3'd4
  } op_class_e;

  localparam logic [3:0] REG_SP = 4'd13;
  localparam logic [3:0] REG_LR = 4'd14;
  localparam logic [3:0] REG_PC = 4'd15;

  localparam int unsigned CALL_LINK_OFS  = 4;
  localparam int unsigned PRELUDE_PC_OFS = 8;
endpackage

// File: rtl/ras_classify.sv
module ras_classify
  import ras_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic          op_valid,
  input  logic [2:0]    op_class,
  input  logic [3:0]    op_dst,
  input  logic [3:0]    op_src,
  input  logic [AW-1:0] op_addr,
  output logic          push_req,
  output logic          pop_req,
  output logic [AW-1:0] push_addr
);
  op_class_e cls;
  assign cls = op_class_e'(op_class);

  always_comb begin
    push_req  = 1'b0;
    pop_req   = 1'b0;
    push_addr = op_addr + AW'(CALL_LINK_OFS);
    if (op_valid) begin
      case (cls)
        OPC_BL_IMM, OPC_BLX_IMM: push_req = 1'b1;
        OPC_LOAD: pop_req = (op_dst == REG_PC) && (op_src == REG_SP);
        OPC_MOVALU: begin
          if (op_dst == REG_PC && op_src == REG_LR) begin
            pop_req = 1'b1;
          end else if (op_dst == REG_LR && op_src == REG_PC) begin
            push_req  = 1'b1;
            push_addr = op_addr + AW'(PRELUDE_PC_OFS);
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/ras_stack.sv
module ras_stack #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned AW    = 32,
  localparam int unsigned PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic [AW-1:0] push_data,
  output logic          pop_hit,
  output logic [AW-1:0] pop_data,
  output logic [CW-1:0] occ
);
  localparam logic [PW-1:0] LAST_IDX = PW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [AW-1:0] mem_q [DEPTH];
  logic [PW-1:0] top_q, top_mid, top_d, wr_idx;
  logic [CW-1:0] occ_q, occ_mid, occ_d;

  function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
    return (p == LAST_IDX) ? '0 : p + 1'b1;
  endfunction

  function automatic logic [PW-1:0] ptr_dec(input logic [PW-1:0] p);
    return (p == '0) ? LAST_IDX : p - 1'b1;
  endfunction

  // Pop is resolved first, then any push lands on the adjusted pointer.
  always_comb begin
    pop_hit  = pop && (occ_q != '0);
    pop_data = mem_q[top_q];
    top_mid  = pop_hit ? ptr_dec(top_q) : top_q;
    occ_mid  = pop_hit ? occ_q - 1'b1 : occ_q;
    wr_idx   = ptr_inc(top_mid);
    top_d    = push ? wr_idx : top_mid;
    if (push) occ_d = (occ_mid == FULL_CNT) ? FULL_CNT : occ_mid + 1'b1;
    else      occ_d = occ_mid;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      top_q <= LAST_IDX;
      occ_q <= '0;
    end else begin
      top_q <= top_d;
      occ_q <= occ_d;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rst_n)                         mem_q[i] <= '0;
      else if (push && wr_idx == PW'(i))  mem_q[i] <= push_data;
    end
  end

  assign occ = occ_q;
endmodule

// File: rtl/ras_predictor.sv
module ras_predictor #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned AW    = 32,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flow_en,
  input  logic          stack_en,
  input  logic          op_valid,
  input  logic [2:0]    op_class,
  input  logic [3:0]    op_dst,
  input  logic [3:0]    op_src,
  input  logic [AW-1:0] op_addr,
  output logic          pred_valid,
  output logic [AW-1:0] pred_target
);
  logic          push_req, pop_req, active;
  logic          pop_hit;
  logic [AW-1:0] push_addr, pop_data;
  logic [CW-1:0] occ;
  logic          pv_q;
  logic [AW-1:0] pt_q;

  ras_classify #(.AW(AW)) u_classify (
    .op_valid (op_valid),
    .op_class (op_class),
    .op_dst   (op_dst),
    .op_src   (op_src),
    .op_addr  (op_addr),
    .push_req (push_req),
    .pop_req  (pop_req),
    .push_addr(push_addr)
  );

  assign active = flow_en && stack_en;

  ras_stack #(.DEPTH(DEPTH), .AW(AW)) u_stack (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (active && push_req),
    .pop      (active && pop_req),
    .push_data(push_addr),
    .pop_hit  (pop_hit),
    .pop_data (pop_data),
    .occ      (occ)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pv_q <= 1'b0;
      pt_q <= '0;
    end else begin
      pv_q <= pop_hit;
      if (pop_hit) pt_q <= pop_data;
    end
  end

  assign pred_valid  = pv_q;
  assign pred_target = pt_q;
endmodule

// File: rtl/ras_predictor_chk.sv
module ras_predictor_chk #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned CW    = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          flow_en,
  input logic          stack_en,
  input logic          op_valid,
  input logic [2:0]    op_class,
  input logic          pred_valid,
  input logic [CW-1:0] occ
);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  assert_occ_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= FULL_CNT);

  assert_disabled_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(flow_en && stack_en) |=> !pred_valid && $stable(occ));

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> !pred_valid && $stable(occ));

  assert_empty_no_pred_R8: assert property (@(posedge clk) disable iff (!rst_n)
    occ == '0 |=> !pred_valid);

  assert_pop_shrinks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && pred_valid |-> ($past(occ) != '0) && (occ == $past(occ) - 1'b1));

  assert_call_grows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && flow_en && stack_en && (op_class == 3'd1 || op_class == 3'd2)
     && occ < FULL_CNT) |=> occ == $past(occ) + 1'b1);
endmodule

bind ras_predictor ras_predictor_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .flow_en   (flow_en),
  .stack_en  (stack_en),
  .op_valid  (op_valid),
  .op_class  (op_class),
  .pred_valid(pred_valid),
  .occ       (occ)
);

// File: tb/test_ras_predictor.sv
`timescale 1ns/1ps
module test_ras_predictor;
  localparam int AW = 32;
  localparam int NV = 10;

  logic clk = 1'b0;
  logic rst_n, flow_en, stack_en, op_valid;
  logic [2:0] op_class;
  logic [3:0] op_dst, op_src;
  logic [AW-1:0] op_addr;
  logic pred_valid;
  logic [AW-1:0] pred_target;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ras_predictor #(.DEPTH(4), .AW(AW)) i_ras_predictor (
    .clk(clk), .rst_n(rst_n), .flow_en(flow_en), .stack_en(stack_en),
    .op_valid(op_valid), .op_class(op_class), .op_dst(op_dst), .op_src(op_src),
    .op_addr(op_addr), .pred_valid(pred_valid), .pred_target(pred_target)
  );

  // {valid, class, dst, src, addr, exp_valid, exp_target}
  localparam logic [76:0] VEC [NV] = '{
    {1'b1, 3'd1, 4'd0,  4'd0,  32'h0000_0100, 1'b0, 32'h0},          // R2 BL push 0x104
    {1'b1, 3'd2, 4'd0,  4'd0,  32'h0000_0200, 1'b0, 32'h0},          // R2 BLX push 0x204
    {1'b1, 3'd4, 4'd14, 4'd15, 32'h0000_0300, 1'b0, 32'h0},          // R3 prelude push 0x308
    {1'b1, 3'd3, 4'd15, 4'd13, 32'h0000_0400, 1'b1, 32'h0000_0308},  // R4 R3 R6
    {1'b1, 3'd4, 4'd15, 4'd14, 32'h0000_0500, 1'b1, 32'h0000_0204},  // R5 R6
    {1'b1, 3'd0, 4'd15, 4'd14, 32'h0000_0600, 1'b0, 32'h0},          // R11 class other
    {1'b1, 3'd3, 4'd15, 4'd0,  32'h0000_0700, 1'b0, 32'h0},          // R11 wrong base
    {1'b0, 3'd3, 4'd15, 4'd13, 32'h0000_0800, 1'b0, 32'h0},          // R10 not valid
    {1'b1, 3'd4, 4'd15, 4'd14, 32'h0000_0900, 1'b1, 32'h0000_0104},  // R5 R2 R11 R10
    {1'b1, 3'd4, 4'd15, 4'd14, 32'h0000_0A00, 1'b0, 32'h0}           // R8 empty
  };

  task automatic check(input string tag, input logic ev, input logic [AW-1:0] et);
    n_cmp++;
    if (pred_valid !== ev || (ev && pred_target !== et)) begin
      n_bad++;
      $display("FAIL %s: got valid=%0b target=%h, expected valid=%0b target=%h",
               tag, pred_valid, pred_target, ev, et);
    end
  endtask

  task automatic do_op(input logic v, input logic [2:0] c, input logic [3:0] d,
                       input logic [3:0] s, input logic [AW-1:0] a);
    @(negedge clk);
    op_valid = v; op_class = c; op_dst = d; op_src = s; op_addr = a;
    @(posedge clk);
    #1;
    op_valid = 1'b0;
  endtask

  task automatic call_op(input logic [AW-1:0] a);
    do_op(1'b1, 3'd1, 4'd0, 4'd0, a);
  endtask

  task automatic ret_op();
    do_op(1'b1, 3'd4, 4'd15, 4'd14, 32'h0000_0F00);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #20000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got timeout, expected completion");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; flow_en = 1'b0; stack_en = 1'b0;
    op_valid = 1'b0; op_class = 3'd0; op_dst = 4'd0; op_src = 4'd0; op_addr = '0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset state", 1'b0, '0);
    @(negedge clk);
    rst_n = 1'b1; flow_en = 1'b1; stack_en = 1'b1;

    for (int i = 0; i < NV; i++) begin
      do_op(VEC[i][76], VEC[i][75:73], VEC[i][72:69], VEC[i][68:65], VEC[i][64:33]);
      check($sformatf("table row %0d (R2..R11)", i), VEC[i][32], VEC[i][31:0]);
    end

    // R7: five pushes into four entries, oldest lost
    for (int k = 0; k < 5; k++) call_op(32'h0000_1000 + 32'(k * 16));
    ret_op(); check("R7 pop 1", 1'b1, 32'h0000_1044);
    ret_op(); check("R7 pop 2", 1'b1, 32'h0000_1034);
    ret_op(); check("R7 pop 3", 1'b1, 32'h0000_1024);
    ret_op(); check("R7 pop 4", 1'b1, 32'h0000_1014);
    ret_op(); check("R7 R8 pop 5 empty", 1'b0, '0);

    // R9: disabled stack neither pushes nor pops
    call_op(32'h0000_2000);
    @(negedge clk); stack_en = 1'b0;
    call_op(32'h0000_3000);
    ret_op(); check("R9 stack_en low pop", 1'b0, '0);
    @(negedge clk); stack_en = 1'b1; flow_en = 1'b0;
    ret_op(); check("R9 flow_en low pop", 1'b0, '0);
    @(negedge clk); flow_en = 1'b1;
    ret_op(); check("R9 contents kept", 1'b1, 32'h0000_2004);
    ret_op(); check("R9 no stray push", 1'b0, '0);

    // R1: reset empties the stack
    call_op(32'h0000_4000);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    ret_op(); check("R1 pop after reset", 1'b0, '0);

    done = 1'b1;
    finish_run();
  end
endmodule